// File: doc/BRIEF.md
# Data-Side Load/Store Unit with Memory-Mapped Pad Ports

This block is the data-memory interface of a small 16-bit processor. Each cycle it can take one word request: a valid strobe, a write-enable, a 16-bit address and 16-bit write data. The address is decoded against one unified 16-bit space. It selects a four-word scratch memory, a 16-bit output port register that drives output pads, or a 16-bit input port that reads input pads.

Load data comes back combinationally in the same cycle, with no handshake. A stored value takes effect at the next rising clock edge. The input pads pass through a two-flop synchronizer before a load can see them. Stores to read-only or unmapped locations are dropped, and loads from unmapped locations return zero.

Top module: `lsu_mmio`

## Requirements
- R1: After reset is released, the output pads are 0x0000 and every scratch memory word reads back as 0x0000.
- R2: A store (valid=1, write=1) to address 0xFC00 drives the write data onto the output pads from the next rising edge. The pads hold that value until the next store to 0xFC00.
- R3: A load (valid=1, write=0) from 0xFC00 returns the current output pad value in the same cycle.
- R4: A load from 0xFC02 returns the input pad value that was present at the rising edge before the previous one. This is a two-flop synchronized sample.
- R5: Any address below 0xFC00 selects scratch word addr[2:1]. A store there writes that word at the next rising edge. A load from there returns that word in the same cycle.
- R6: For scratch accesses, address bit 0 and bits 15:3 are ignored. For example, 0x1235 and 0x0004 both select word 2.
- R7: A store to 0xFC02, or to any address at or above 0xFC00 other than 0xFC00, changes neither the output pads nor any scratch word.
- R8: A load from an address at or above 0xFC00 other than 0xFC00 and 0xFC02 returns 0x0000.
- R9: Load data is 0x0000 in any cycle that is not a load (valid=0, or write=1).
- R10: When valid is 0, the write-enable, address and data are ignored: neither the output pads nor the scratch memory change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_we_i | input | 1 | 1 = store word, 0 = load word |
| req_addr_i | input | 16 | Byte address in the unified space |
| req_wdata_i | input | 16 | Store data |
| rdata_o | output | 16 | Load data to register write-back |
| in_pads_i | input | 16 | Asynchronous input pad levels |
| out_pads_o | output | 16 | Output port register to pads |

## Verification
The hardest case is telling the two synchronizer delays apart from the ports. A read of 0xFC02 only exposes the pad history if the pads change on consecutive cycles while loads are issued back to back. The stimulus therefore steps the input pads through distinct values every cycle and loads 0xFC02 each cycle. An error of one stage too few or one too many then shows up as the wrong value in the history. Aliased and unmapped stores are placed between known scratch contents and output values, so that any stray write shows up on a later read.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_MEM  = 2'd1,
    TGT_OUT  = 2'd2,
    TGT_IN   = 2'd3
  } tgt_e;
endpackage

// File: rtl/lsu_decode.sv
`timescale 1ns/1ps
module lsu_decode import lsu_pkg::*; #(
  parameter int          ADDR_W    = 16,
  parameter int          MEM_WORDS = 4,
  parameter logic [15:0] OUT_ADDR  = 16'hFC00,
  parameter logic [15:0] IN_ADDR   = 16'hFC02,
  localparam int         IDX_W     = $clog2(MEM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output tgt_e              tgt_o,
  output logic [IDX_W-1:0]  idx_o
);
  // Everything below the output port address is scratch memory
  always_comb begin
    if (addr_i < ADDR_W'(OUT_ADDR))       tgt_o = TGT_MEM;
    else if (addr_i == ADDR_W'(OUT_ADDR)) tgt_o = TGT_OUT;
    else if (addr_i == ADDR_W'(IN_ADDR))  tgt_o = TGT_IN;
    else                                  tgt_o = TGT_NONE;
  end

  // Word-aligned index: bit 0 is the byte offset
  assign idx_o = addr_i[IDX_W:1];
endmodule

// File: rtl/lsu_scratch_mem.sv
`timescale 1ns/1ps
module lsu_scratch_mem #(
  parameter int  DATA_W    = 16,
  parameter int  MEM_WORDS = 4,
  localparam int IDX_W     = $clog2(MEM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [MEM_WORDS];

  for (genvar w = 0; w < MEM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[w] <= '0;
      else if (we_i && idx_i == IDX_W'(w))     mem_q[w] <= wdata_i;
    end

    p_word_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && idx_i == IDX_W'(w)) |=> $stable(mem_q[w]));
    p_word_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && idx_i == IDX_W'(w)) |=> mem_q[w] == $past(wdata_i));
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/lsu_out_port.sv
`timescale 1ns/1ps
module lsu_out_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] port_o
);
  logic [DATA_W-1:0] port_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   port_q <= '0;
    else if (we_i) port_q <= wdata_i;
  end

  assign port_o = port_q;

  p_port_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> port_o == $past(wdata_i));
  p_port_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(port_o));
endmodule

// File: rtl/lsu_in_sync.sv
`timescale 1ns/1ps
module lsu_in_sync #(
  parameter int  DATA_W = 16,
  parameter int  STAGES = 2,
  localparam int CNT_W  = $clog2(STAGES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pads_i,
  output logic [DATA_W-1:0] sync_o
);
  logic [DATA_W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= pads_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

  // Counts edges since reset so the latency check never looks before reset
  logic [CNT_W-1:0] fill_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          fill_q <= '0;
    else if (fill_q != CNT_W'(STAGES))    fill_q <= fill_q + 1'b1;
  end

  if (STAGES == 2) begin : g_chk2
    p_sync_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fill_q == CNT_W'(STAGES) |-> sync_o == $past(pads_i, 2));
  end
endmodule

// File: rtl/lsu_mmio.sv
`timescale 1ns/1ps
module lsu_mmio import lsu_pkg::*; #(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 16,
  parameter int          MEM_WORDS   = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] OUT_ADDR    = 16'hFC00,
  parameter logic [15:0] IN_ADDR     = 16'hFC02,
  localparam int         IDX_W       = $clog2(MEM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] in_pads_i,
  output logic [DATA_W-1:0] out_pads_o
);
  tgt_e              tgt;
  logic [IDX_W-1:0]  idx;
  logic              st_en, ld_en;
  logic [DATA_W-1:0] mem_rdata, in_sync;

  assign st_en = req_valid_i &  req_we_i;
  assign ld_en = req_valid_i & ~req_we_i;

  lsu_decode #(
    .ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS),
    .OUT_ADDR(OUT_ADDR), .IN_ADDR(IN_ADDR)
  ) u_decode (
    .addr_i(req_addr_i), .tgt_o(tgt), .idx_o(idx)
  );

  lsu_scratch_mem #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) u_mem (
    .clk_i, .rst_ni,
    .we_i   (st_en && tgt == TGT_MEM),
    .idx_i  (idx),
    .wdata_i(req_wdata_i),
    .rdata_o(mem_rdata)
  );

  lsu_out_port #(.DATA_W(DATA_W)) u_out (
    .clk_i, .rst_ni,
    .we_i   (st_en && tgt == TGT_OUT),
    .wdata_i(req_wdata_i),
    .port_o (out_pads_o)
  );

  lsu_in_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .pads_i(in_pads_i),
    .sync_o(in_sync)
  );

  always_comb begin
    rdata_o = '0;
    if (ld_en) begin
      unique case (tgt)
        TGT_MEM: rdata_o = mem_rdata;
        TGT_OUT: rdata_o = out_pads_o;
        TGT_IN:  rdata_o = in_sync;
        default: rdata_o = '0;
      endcase
    end
  end

  p_out_readback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_en && req_addr_i == ADDR_W'(OUT_ADDR)) |-> rdata_o == out_pads_o);
  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_en && req_addr_i > ADDR_W'(OUT_ADDR) && req_addr_i != ADDR_W'(IN_ADDR))
      |-> rdata_o == '0);
  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_en |-> rdata_o == '0);
  p_no_valid_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(out_pads_o));
endmodule

// File: tb/lsu_mmio_bench.sv
`timescale 1ns/1ps
module lsu_mmio_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0;
  logic [15:0] addr = '0, wdata = '0, pads = '0;
  logic [15:0] rdata, out_pads;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  lsu_mmio u_lsu_mmio (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata),
    .rdata_o(rdata), .in_pads_i(pads), .out_pads_o(out_pads)
  );

  // Behavioural reference
  logic [15:0] mem_ref [4];
  logic [15:0] out_ref;
  logic [15:0] pad_hist [$];

  function automatic logic [15:0] exp_rdata();
    if (!(valid && !we))  return 16'h0;
    if (addr < 16'hFC00)  return mem_ref[(addr >> 1) & 3];
    if (addr == 16'hFC00) return out_ref;
    if (addr == 16'hFC02) return pad_hist[0];
    return 16'h0;
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One request cycle: drive at negedge, check before posedge, update model at posedge
  task automatic step(string req, logic v, logic w, logic [15:0] a, logic [15:0] d,
                      logic [15:0] p);
    @(negedge clk);
    valid = v; we = w; addr = a; wdata = d; pads = p;
    #1;
    chk(req, "rdata", rdata, exp_rdata());
    chk(req, "out_pads", out_pads, out_ref);
    @(posedge clk);
    if (v && w) begin
      if (a < 16'hFC00)       mem_ref[(a >> 1) & 3] = d;
      else if (a == 16'hFC00) out_ref = d;
    end
    pad_hist.push_back(p);
    void'(pad_hist.pop_front());
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mem_ref[i] = '0;
    out_ref = '0;
    pad_hist = '{16'h0, 16'h0};
    pads = 16'hBEEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    pads = 16'h0;

    // R1: reset state, all words zero, pads zero
    for (int i = 0; i < 4; i++) step("R1", 1, 0, 16'(i * 2), 16'h0, 16'h0);
    step("R1", 1, 0, 16'hFC00, 16'h0, 16'h0);

    // R2/R3: output port store, hold, readback
    step("R2", 1, 1, 16'hFC00, 16'hA5A5, 16'h0);
    step("R3", 1, 0, 16'hFC00, 16'h0, 16'h0);
    step("R2", 0, 0, 16'h0, 16'h0, 16'h0);
    step("R2", 1, 1, 16'h0002, 16'h1111, 16'h0);
    step("R3", 1, 0, 16'hFC00, 16'h0, 16'h0);

    // R5: write all words, read back
    for (int i = 0; i < 4; i++) step("R5", 1, 1, 16'(i * 2), 16'hC000 + 16'(i), 16'h0);
    for (int i = 0; i < 4; i++) step("R5", 1, 0, 16'(i * 2), 16'h0, 16'h0);

    // R6: aliasing on bit 0 and upper bits
    step("R6", 1, 0, 16'h1235, 16'h0, 16'h0);
    step("R6", 1, 1, 16'hFBFF, 16'h7777, 16'h0);
    step("R6", 1, 0, 16'h0006, 16'h0, 16'h0);
    step("R6", 1, 1, 16'h8001, 16'h2222, 16'h0);
    step("R6", 1, 0, 16'h0000, 16'h0, 16'h0);

    // R7: stores to input port and unmapped space ignored
    step("R7", 1, 1, 16'hFC02, 16'hDEAD, 16'h0);
    step("R7", 1, 1, 16'hFC01, 16'hDEAD, 16'h0);
    step("R7", 1, 1, 16'hFFFE, 16'hDEAD, 16'h0);
    step("R7", 1, 1, 16'hFC04, 16'hDEAD, 16'h0);
    for (int i = 0; i < 4; i++) step("R7", 1, 0, 16'(i * 2), 16'h0, 16'h0);
    step("R7", 1, 0, 16'hFC00, 16'h0, 16'h0);

    // R8: unmapped loads return zero
    step("R8", 1, 0, 16'hFC01, 16'h0, 16'h0);
    step("R8", 1, 0, 16'hFC04, 16'h0, 16'h0);
    step("R8", 1, 0, 16'hFFFF, 16'h0, 16'h0);

    // R4: pad value changes each cycle while loading the input port
    for (int i = 0; i < 8; i++) step("R4", 1, 0, 16'hFC02, 16'h0, 16'h1000 + 16'(i * 16'h0101));
    for (int i = 0; i < 3; i++) step("R4", 1, 0, 16'hFC02, 16'h0, 16'h5A5A);

    // R9: non-load cycles drive zero
    step("R9", 0, 0, 16'h0000, 16'h0, 16'h5A5A);
    step("R9", 0, 0, 16'hFC02, 16'h0, 16'h5A5A);
    step("R9", 1, 1, 16'hFC03, 16'h0, 16'h5A5A);

    // R10: valid low ignores write strobe
    step("R10", 0, 1, 16'hFC00, 16'h9999, 16'h0);
    step("R10", 0, 1, 16'h0002, 16'h9999, 16'h0);
    step("R10", 1, 0, 16'h0002, 16'h0, 16'h0);
    step("R10", 1, 0, 16'hFC00, 16'h0, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule